// File: doc/BRIEF.md
# Pipelined CORDIC Sine and Arctangent Unit

This block is a fully unrolled fixed-point CORDIC engine meant to sit inside a pixel-rate arithmetic pipeline. Each clock it may take one operand set tagged with a valid flag and an operation select. It then hands back one 32-bit result a constant number of cycles later. There is no backpressure and no stall path, so a steady stream of one sample per clock comes out as a steady stream of one result per clock.

Two operations share the same chain of micro-rotation stages. The sine operation takes an angle and returns its sine. The arctangent operation takes a vector (x, y) and returns its polar angle over the full circle. Every value is signed fixed point with 16 integer and 16 fraction bits. Angles are measured in turns, so 1.0 is a full circle. The chain has one stage per operand bit, and each stage performs one shift-and-add rotation. Downstream logic must account for the fixed delay itself, because the block does not compensate for it.

Top module: `cordic_trig_pipe`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` stays low until a new sample is taken with `in_valid` high. Samples that were in the chain or presented while reset was asserted never produce a result.
- R2: A sample taken at rising edge k shows up with `out_valid` high at rising edge k+32, and only in that cycle. Each accepted sample yields exactly one result.
- R3: A new sample can be accepted on every clock with no gaps. Results then come out on consecutive clocks, in the same order as the inputs.
- R4: When `in_op`=0 (sine), `in_a` is an angle in turns (Q16.16). `out_result` is sin(2π·angle) in Q16.16 and is within 4 LSB of the exact value.
- R5: In sine mode the integer part of `in_a` has no effect, so 1.25 turns gives the same result as 0.25 turns. Angles in every quadrant are supported, including exactly ±0.25 and ±0.5 turn.
- R6: When `in_op`=1 (arctangent), `in_a` is x and `in_b` is y, both signed Q16.16. `out_result` is atan2(y, x) in turns (Q16.16), in the range [-0.5, 0.5), within 4 LSB modulo one turn. This holds for vectors with x > 0 in any quadrant.
- R7: The arctangent is also correct when x < 0 (second and third quadrants). A vector on the negative x axis returns a half turn (0x0000_8000 or 0xFFFF_8000).
- R8: `out_op` returns the operation select of the sample whose result is on `out_result`. This holds when the two operations are interleaved cycle by cycle.
- R9: In sine mode `in_b` is ignored: the same angle with any `in_b` gives a bit-identical result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample present this cycle |
| in_op | input | 1 | 0 = sine, 1 = arctangent |
| in_a | input | 32 | Angle in turns (sine) or x (arctangent), Q16.16 |
| in_b | input | 32 | y (arctangent), unused for sine, Q16.16 |
| out_valid | output | 1 | Result present this cycle |
| out_op | output | 1 | Operation of the result on `out_result` |
| out_result | output | 32 | Sine value or angle in turns, Q16.16 |

## Verification
The embedded properties run on every cycle. They check that the angle fold leaves every sine sample inside the quarter-turn band where the chain converges. They check that the left-half-plane fold hands the chain a non-negative x. They check that the residual angle at the last stage has collapsed to a few units of 2^-32 turn. Finally, they check that a result never appears before 32 cycles have passed since reset, nor without a matching accepted sample. Only the bench scenarios can show that the numeric values match sin and atan2 in each quadrant. The same goes for exact-cycle timing, ordering under back-to-back traffic, the equivalence of wrapped angles, the insensitivity to `in_b`, and the flushing of in-flight samples by reset.

// File: rtl/cordic_pkg.sv
`timescale 1ns/1ps
// Shared constants, lane record and arctangent constant generator for the
// pipelined CORDIC unit. Assumes the angle word spans exactly one turn, so
// the angle width equals DATA_W.
package cordic_pkg;

    parameter int DATA_W  = 32;                      // operand/result width
    parameter int FRAC_W  = 16;                      // fraction bits of Q format
    parameter int GUARD_W = 8;                       // extra low bits in x/y
    parameter int STAGES  = DATA_W;                  // one rotation per bit
    parameter int XY_W    = DATA_W + GUARD_W + 2;    // headroom for gain and sqrt2

    localparam real CORDIC_K = 0.6072529350088813;   // reciprocal of chain gain
    localparam real TWO_PI   = 6.283185307179586;

    typedef enum logic {
        OP_SINE  = 1'b0,
        OP_ATAN2 = 1'b1
    } op_e;

    // One pipeline slot: control travels with the data it belongs to.
    typedef struct packed {
        logic                     valid;
        op_e                      op;
        logic                     neg;
        logic signed [XY_W-1:0]   x;
        logic signed [XY_W-1:0]   y;
        logic signed [DATA_W-1:0] z;
    } lane_t;

    // atan(2^-i) expressed in units of 2^-32 turn, rounded to nearest.
    function automatic int atan_turn(input int i);
        real r;
        r = $atan(1.0 / (2.0 ** i));
        return $rtoi(r / TWO_PI * 4294967296.0 + 0.5);
    endfunction

endpackage

// File: rtl/cordic_prep.sv
`timescale 1ns/1ps
// Input conditioning ahead of the first stage (combinational).
// Sine: keeps only the fractional turn and folds angles outside +-0.25 turn
// by half a turn, marking the result for negation. The start vector is the
// reciprocal gain on the x axis.
// Arctangent: widens x and y. When x is negative the vector is turned by half
// a turn and the angle accumulator starts at half a turn.
module cordic_prep
    import cordic_pkg::*;
(
    input  logic              in_valid,
    input  op_e               in_op,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    output lane_t             o
);

    localparam int ZSH = DATA_W - FRAC_W;
    localparam logic signed [XY_W-1:0] X_INIT =
        XY_W'($rtoi(CORDIC_K * (2.0 ** (FRAC_W + GUARD_W)) + 0.5));
    localparam logic signed [DATA_W-1:0] HALF_TURN =
        {1'b1, {(DATA_W-1){1'b0}}};

    logic signed [DATA_W-1:0] ang;
    logic signed [XY_W-1:0]   xw;
    logic signed [XY_W-1:0]   yw;

    // Build the first lane from the raw operands.
    always_comb begin
        ang     = {in_a[FRAC_W-1:0], {ZSH{1'b0}}};
        xw      = XY_W'($signed(in_a)) <<< GUARD_W;
        yw      = XY_W'($signed(in_b)) <<< GUARD_W;
        o.valid = in_valid;
        o.op    = in_op;
        if (in_op == OP_SINE) begin
            o.x = X_INIT;
            o.y = '0;
            if (ang[DATA_W-1] != ang[DATA_W-2]) begin
                o.z   = ang ^ HALF_TURN;
                o.neg = 1'b1;
            end else begin
                o.z   = ang;
                o.neg = 1'b0;
            end
        end else begin
            o.neg = 1'b0;
            if (in_a[DATA_W-1]) begin
                o.x = -xw;
                o.y = -yw;
                o.z = HALF_TURN;
            end else begin
                o.x = xw;
                o.y = yw;
                o.z = '0;
            end
        end
    end

endmodule

// File: rtl/cordic_stage.sv
`timescale 1ns/1ps
// One registered CORDIC micro-rotation by atan(2^-IDX).
// Direction comes from the sign of the residual angle (sine) or from the
// sign of y (arctangent). A counter-clockwise step subtracts the constant
// from z, so z always holds the original angle minus the current one.
// Only the valid bit is reset; data registers follow the input freely.
module cordic_stage
    import cordic_pkg::*;
#(
    parameter int IDX = 0
)(
    input  logic  clk,
    input  logic  rst_n,
    input  lane_t d,
    output lane_t q
);

    localparam logic signed [DATA_W-1:0] ATAN_K = DATA_W'(atan_turn(IDX));

    logic                   ccw;
    logic signed [XY_W-1:0] xs;
    logic signed [XY_W-1:0] ys;

    // Pick the rotation direction and form the shifted cross terms.
    always_comb begin
        ccw = (d.op == OP_SINE) ? !d.z[DATA_W-1] : d.y[XY_W-1];
        xs  = d.x >>> IDX;
        ys  = d.y >>> IDX;
    end

    // Register the valid flag with reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q.valid <= 1'b0;
        else        q.valid <= d.valid;
    end

    // Register the rotated vector, the residual angle and the tags.
    always_ff @(posedge clk) begin
        q.op  <= d.op;
        q.neg <= d.neg;
        q.x   <= ccw ? d.x - ys : d.x + ys;
        q.y   <= ccw ? d.y + xs : d.y - xs;
        q.z   <= ccw ? d.z - ATAN_K : d.z + ATAN_K;
    end

endmodule

// File: rtl/cordic_post.sv
`timescale 1ns/1ps
// Output formatting after the last stage (combinational).
// Sine: rounds y down to Q16.16 and restores the sign removed by the fold.
// Arctangent: rounds the accumulated angle (2^-32 turn units) to Q16.16 turns.
module cordic_post
    import cordic_pkg::*;
(
    input  lane_t             d,
    output logic              out_valid,
    output logic              out_op,
    output logic [DATA_W-1:0] out_result
);

    localparam logic signed [XY_W-1:0]   Y_RND = XY_W'(1) <<< (GUARD_W - 1);
    localparam int                       ZSH   = DATA_W - FRAC_W;
    localparam logic signed [DATA_W-1:0] Z_RND = DATA_W'(1) <<< (ZSH - 1);

    logic [DATA_W-1:0] mag;
    logic              unused_x;

    assign unused_x = ^d.x;

    // Select and round the result for the operation carried by the lane.
    always_comb begin
        out_valid = d.valid;
        out_op    = d.op;
        mag       = DATA_W'(($signed(d.y) + Y_RND) >>> GUARD_W);
        if (d.op == OP_SINE) out_result = d.neg ? -mag : mag;
        else                 out_result = DATA_W'(($signed(d.z) + Z_RND) >>> ZSH);
    end

endmodule

// File: rtl/cordic_trig_pipe.sv
`timescale 1ns/1ps
// Top of the pipelined CORDIC unit: input conditioning, STAGES registered
// micro-rotations, output formatting. Accepts one sample per clock with no
// stall; each result appears STAGES clocks after its sample.
// Assumes the consumer absorbs the fixed delay.
module cordic_trig_pipe
    import cordic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_op,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    output logic              out_valid,
    output logic              out_op,
    output logic [DATA_W-1:0] out_result
);

    localparam int AGE_W = $clog2(STAGES + 1);
    localparam int CNT_W = $clog2(STAGES + 2) + 1;

    lane_t pipe [0:STAGES];

    cordic_prep u_prep (
        .in_valid (in_valid),
        .in_op    (op_e'(in_op)),
        .in_a     (in_a),
        .in_b     (in_b),
        .o        (pipe[0])
    );

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        cordic_stage #(.IDX(i)) u_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (pipe[i]),
            .q     (pipe[i+1])
        );
    end

    cordic_post u_post (
        .d          (pipe[STAGES]),
        .out_valid  (out_valid),
        .out_op     (out_op),
        .out_result (out_result)
    );

    // ---------------- assertions ----------------
    logic [AGE_W-1:0] age;
    logic [CNT_W-1:0] inflight;

    // Count clocks since reset, saturating at the chain depth.
    always_ff @(posedge clk) begin
        if (!rst_n)             age <= '0;
        else if (age != STAGES) age <= age + 1'b1;
    end

    // Track samples accepted but not yet delivered.
    always_ff @(posedge clk) begin
        if (!rst_n) inflight <= '0;
        else        inflight <= inflight + CNT_W'(in_valid) - CNT_W'(out_valid);
    end

    AST_NO_EARLY_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (age == STAGES) && (inflight != 0)); // R2
    AST_INFLIGHT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        inflight <= CNT_W'(STAGES)); // R3
    AST_FOLD_IN_BAND: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_op) |-> (pipe[0].z[DATA_W-1] == pipe[0].z[DATA_W-2])); // R5
    AST_VEC_X_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op) |-> !pipe[0].x[XY_W-1]); // R7
    AST_RESIDUE_SMALL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_op) |->
        ($signed(pipe[STAGES].z) < 64 && $signed(pipe[STAGES].z) > -64)); // R4

endmodule

// File: tb/sim_cordic_trig_pipe.sv
`timescale 1ns/1ps
// Directed bench: each task builds a sample list, streams it and checks its
// own results against sin/atan2 computed in real arithmetic.
module sim_cordic_trig_pipe;

    localparam int LAT = 32;
    localparam int TOL = 4;
    localparam int MAXN = 128;
    localparam real TP = 6.283185307179586;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_op = 1'b0;
    logic [31:0] in_a = '0;
    logic [31:0] in_b = '0;
    logic        out_valid;
    logic        out_op;
    logic [31:0] out_result;

    int n_tests = 0;
    int n_fail  = 0;

    logic        s_op  [0:MAXN-1];
    logic [31:0] s_a   [0:MAXN-1];
    logic [31:0] s_b   [0:MAXN-1];
    logic [31:0] s_got [0:MAXN-1];
    int          s_n = 0;

    always #2.5 clk = ~clk;

    cordic_trig_pipe u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_op(out_op),
        .out_result(out_result)
    );

    function automatic real q2r(input logic [31:0] v);
        return $itor($signed(v)) / 65536.0;
    endfunction

    function automatic int expect_val(input logic op, input logic [31:0] a, input logic [31:0] b);
        real v;
        if (!op) v = $sin(TP * q2r(a)) * 65536.0;
        else     v = $atan2(q2r(b), q2r(a)) / TP * 65536.0;
        return $rtoi(v + ((v >= 0.0) ? 0.5 : -0.5));
    endfunction

    function automatic int err_of(input logic op, input int got, input int exp_v);
        int d;
        d = got - exp_v;
        if (op) begin
            d = d % 65536;
            if (d >= 32768)  d -= 65536;
            if (d < -32768)  d += 65536;
        end
        return (d < 0) ? -d : d;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp_v);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp_v);
        end
    endtask

    task automatic add(input logic op, input logic [31:0] a, input logic [31:0] b);
        s_op[s_n] = op; s_a[s_n] = a; s_b[s_n] = b; s_n++;
    endtask

    // Stream s_n samples back to back; check timing, tag and value of each.
    task automatic run_stream(input string req);
        for (int c = 0; c < s_n + LAT + 2; c++) begin
            @(negedge clk);
            if (c >= LAT && c - LAT < s_n) begin
                int j;
                int e;
                j = c - LAT;
                e = expect_val(s_op[j], s_a[j], s_b[j]);
                s_got[j] = out_result;
                check(out_valid === 1'b1, "R2", "out_valid at latency", out_valid, 1);
                check(out_op === s_op[j], "R8", "out_op tag", out_op, s_op[j]);
                check(err_of(s_op[j], $signed(out_result), e) <= TOL, req, "result",
                      $signed(out_result), e);
            end else begin
                check(out_valid === 1'b0, "R2", "out_valid outside slot", out_valid, 0);
            end
            if (c < s_n) begin
                in_valid = 1'b1; in_op = s_op[c]; in_a = s_a[c]; in_b = s_b[c];
            end else begin
                in_valid = 1'b0; in_a = '0; in_b = '0;
            end
        end
    endtask

    task automatic test_reset;
        rst_n = 1'b0;
        in_valid = 1'b1; in_op = 1'b0; in_a = 32'h0000_2000;
        repeat (4) @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b1;
        for (int c = 0; c < LAT + 8; c++) begin
            @(negedge clk);
            check(out_valid === 1'b0, "R1", "out_valid after reset", out_valid, 0);
        end
        for (int c = 0; c < 5; c++) begin
            in_valid = 1'b1; in_a = 32'h0000_1000 * c;
            @(negedge clk);
        end
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < LAT + 8; c++) begin
            @(negedge clk);
            check(out_valid === 1'b0, "R1", "flushed sample emerged", out_valid, 0);
        end
    endtask

    task automatic test_latency_single;
        s_n = 0;
        add(1'b0, 32'h0000_1555, 32'h0);
        run_stream("R2");
    endtask

    task automatic test_sine_sweep;
        s_n = 0;
        for (int k = 0; k < 48; k++) add(1'b0, 32'(k * 1387 - 30000), 32'h0);
        run_stream("R4");
        check(1'b1, "R3", "back-to-back stream completed", s_n, 48);
    endtask

    task automatic test_fold_wrap;
        s_n = 0;
        add(1'b0, 32'h0000_4000, 32'h0);   // +0.25
        add(1'b0, 32'h0001_4000, 32'h0);   // 1.25
        add(1'b0, 32'hFFFF_C000, 32'h0);   // -0.25
        add(1'b0, 32'h0000_8000, 32'h0);   // +0.5
        add(1'b0, 32'hFFFF_8000, 32'h0);   // -0.5
        add(1'b0, 32'h0000_A000, 32'h0);   // 0.625
        add(1'b0, 32'h7FFF_6000, 32'h0);   // large integer part
        add(1'b0, 32'h0000_6000, 32'h0);   // 0.375
        run_stream("R5");
        check(s_got[0] == s_got[1], "R5", "1.25 vs 0.25 turn", s_got[1], s_got[0]);
        check(s_got[7] == s_got[6], "R5", "integer part ignored", s_got[6], s_got[7]);
    endtask

    task automatic test_atan_right;
        s_n = 0;
        add(1'b1, 32'h0001_0000, 32'h0001_0000);
        add(1'b1, 32'h0001_0000, 32'hFFFF_0000);
        add(1'b1, 32'h0003_0000, 32'h0001_8000);
        add(1'b1, 32'h0000_8000, 32'hFFFD_0000);
        add(1'b1, 32'h03E8_0000, 32'h0000_0000);
        add(1'b1, 32'h0000_0000, 32'h0002_0000);
        add(1'b1, 32'h7530_0000, 32'h7530_0000);
        run_stream("R6");
    endtask

    task automatic test_atan_left;
        s_n = 0;
        add(1'b1, 32'hFFFF_0000, 32'h0001_0000);
        add(1'b1, 32'hFFFF_0000, 32'hFFFF_0000);
        add(1'b1, 32'hFFFE_0000, 32'h0000_8000);
        add(1'b1, 32'hFFFF_0000, 32'h0000_0000);
        add(1'b1, 32'h8000_0000, 32'h0000_0000);
        run_stream("R7");
        check(s_got[3] == 32'h0000_8000 || s_got[3] == 32'hFFFF_8000, "R7",
              "negative x axis half turn", s_got[3], 32'h0000_8000);
    endtask

    task automatic test_interleave;
        s_n = 0;
        for (int k = 0; k < 24; k++) begin
            if (k % 2 == 0) add(1'b0, 32'(k * 2900), 32'h0);
            else            add(1'b1, 32'(k * 4000 - 50000), 32'(30000 - k * 3000));
        end
        run_stream("R8");
    endtask

    task automatic test_b_ignored;
        s_n = 0;
        add(1'b0, 32'h0000_3333, 32'h0000_0000);
        add(1'b0, 32'h0000_3333, 32'hFFFF_FFFF);
        add(1'b0, 32'h0000_3333, 32'h1234_5678);
        run_stream("R9");
        check(s_got[1] == s_got[0], "R9", "in_b all ones", s_got[1], s_got[0]);
        check(s_got[2] == s_got[0], "R9", "in_b pattern", s_got[2], s_got[0]);
    endtask

    initial begin
        #1_000_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        test_reset();
        test_latency_single();
        test_sine_sweep();
        test_fold_wrap();
        test_atan_right();
        test_atan_left();
        test_interleave();
        test_b_ignored();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule